// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Encoder

This block collects sixteen device request lines and hands the processor a single encoded interrupt. It shows one flag that tells the processor an interrupt is waiting, and a 4-bit number that names the source to service. A rising edge on any request line is latched as pending at once. The source mask and the global enable only decide what is presented, so a request that arrives while blocked is kept and shows up once the block is opened again.

The processor takes the presented source with a one-cycle acknowledge pulse. That pulse moves the source from pending to in service. When the handler finishes, an end-of-service pulse retires the most urgent source that is in service. Nesting is allowed, but only upward. A pending source is presented while another is in service only when it has strictly higher priority than every source already in service. Requests that were held off are handed out one per acknowledge.

Source numbers are fixed, and a lower number means higher priority. Source 0 is hardware failure, source 1 is program faults, source 2 is the timer, and sources 3 to 15 are I/O completion or error.

Top module: `irq_prio_enc`

## Requirements
- R1: When `irq_pend` is high, `irq_id` carries the lowest-numbered source that is pending and unmasked. When `irq_pend` is low, `irq_id` is 0.
- R2: Priority is fixed by source number: source 0 is the highest and source 15 the lowest.
- R3: The class map is fixed. Source 0 (hardware failure) outranks source 1 (program fault), and source 1 outranks source 2 (timer). The timer outranks every I/O source on 3 to 15.
- R4: A request becomes pending on the clock edge where its line is first seen high after being low. A line held high does not create a new request.
- R5: Mask bit n set to 1 blocks source n from presentation, and a mask write takes effect on the next edge. A pending request survives being masked and is presented once unmasked.
- R6: While `glob_en` is low, `irq_pend` is low and acknowledges have no effect. Pending requests are kept and are presented when `glob_en` rises.
- R7: An `ack` pulse while `irq_pend` is high clears the presented source from pending and sets its bit in `in_svc` on the next edge. An `ack` while `irq_pend` is low changes nothing.
- R8: An `eoi` pulse clears the lowest-numbered set bit of `in_svc` on the next edge.
- R9: `irq_pend` is high only if the best pending source has a strictly lower number than every bit set in `in_svc`. An equal or lower-priority request waits.
- R10: Several held-off requests are presented one at a time, in priority order, one per acknowledge.
- R11: Reset clears the pending, in-service and mask state, and all request edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 16 | Raw device request lines, bit n is source n |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | New mask value, 1 blocks a source |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | Processor takes the presented source |
| eoi | input | 1 | Processor ends service of the most urgent in-service source |
| irq_pend | output | 1 | An interrupt is waiting for the processor |
| irq_id | output | 4 | Number of the presented source |
| in_svc | output | 16 | Sources currently in service |

## Verification
The encoder is driven with these patterns:
- A single request.
- Two requests raised together at opposite ends of the priority range.
- A lower-priority request arriving during service, which must wait.
- A higher-priority request arriving during service, which must preempt.
- A re-raised request on the source already in service.

Together these separate a correct strict comparison from a less-or-equal one, and show that the lowest index wins. Blocked arrivals are tried under the mask and under the global disable; each shows that holding a request is kept apart from presenting it. A line left high across an acknowledge checks the edge detection. An acknowledge given while nothing is presented, in the same cycle as an end-of-service, shows that the handshake is gated by the flag.

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC = 16,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_in,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            glob_en,
  input  logic            ack,
  input  logic            eoi,
  output logic            irq_pend,
  output logic [IDW-1:0]  irq_id,
  output logic [NSRC-1:0] in_svc
);

  localparam int SRC_HWFAIL = 0;
  localparam int SRC_PROG   = 1;
  localparam int SRC_TIMER  = 2;
  localparam int SRC_IO_LO  = 3;

  logic [NSRC-1:0] req_q, pend_q, mask_q, svc_q;
  logic [NSRC-1:0] rise, cand, ack_set, eoi_clr;
  logic [IDW-1:0]  best_id;
  logic            best_ok;
  logic [IDW:0]    top_svc;

  assign rise = req_in & ~req_q;
  assign cand = pend_q & ~mask_q;

  always_comb begin
    best_id = '0;
    best_ok = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        best_id = IDW'(i);
        best_ok = 1'b1;
      end
    end
  end

  always_comb begin
    top_svc = (IDW+1)'(NSRC);
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (svc_q[i]) top_svc = (IDW+1)'(i);
    end
  end

  assign irq_pend = glob_en && best_ok && ({1'b0, best_id} < top_svc);
  assign irq_id   = irq_pend ? best_id : '0;
  assign in_svc   = svc_q;

  assign ack_set = (ack && irq_pend) ? (NSRC'(1) << best_id) : '0;
  assign eoi_clr = eoi ? (svc_q & (~svc_q + NSRC'(1))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
      mask_q <= '0;
      svc_q  <= '0;
    end else begin
      req_q  <= req_in;
      pend_q <= (pend_q & ~ack_set) | rise;
      svc_q  <= (svc_q & ~eoi_clr) | ack_set;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

endmodule

module irq_prio_enc_chk #(
  parameter int NSRC = 16,
  localparam int IDW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glob_en,
  input logic            ack,
  input logic            eoi,
  input logic            irq_pend,
  input logic [IDW-1:0]  irq_id,
  input logic [NSRC-1:0] in_svc,
  input logic [NSRC-1:0] mask_q
);

  logic [NSRC-1:0] upto;
  assign upto = (NSRC'(2) << irq_id) - NSRC'(1);

  // R6
  gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> glob_en);

  // R1
  idle_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pend |-> irq_id == '0);

  // R5
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> !mask_q[irq_id]);

  // R9
  outrank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (in_svc & upto) == '0);

  // R7
  ack_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_pend && !eoi) |=> in_svc[$past(irq_id)]);

  // R7
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ack && irq_pend) && !eoi) |=> $stable(in_svc));

  // R8
  eoi_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && in_svc != '0) |=> $countones(in_svc) == $countones($past(in_svc)) - 1);

endmodule

bind irq_prio_enc irq_prio_enc_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ack(ack), .eoi(eoi),
  .irq_pend(irq_pend), .irq_id(irq_id), .in_svc(in_svc), .mask_q(mask_q)
);

// File: tb/irq_prio_enc_tb_top.sv
module irq_prio_enc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_in = '0;
  logic        mask_we = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic        glob_en = 1'b0;
  logic        ack = 1'b0;
  logic        eoi = 1'b0;
  logic        irq_pend;
  logic [3:0]  irq_id;
  logic [15:0] in_svc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_enc dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .glob_en(glob_en), .ack(ack), .eoi(eoi),
    .irq_pend(irq_pend), .irq_id(irq_id), .in_svc(in_svc)
  );

  // {req, mask_we, mask, en, ack, eoi, exp_pend, exp_id, exp_svc}
  localparam int NV = 33;
  localparam logic [56:0] VEC [NV] = '{
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000}, // R1 idle
    {16'h0020, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5,  16'h0000}, // R1 R4
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0020}, // R7
    {16'h0100, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0020}, // R9 lower waits
    {16'h0004, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2,  16'h0020}, // R9 preempt
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0024}, // R7 nested
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0020}, // R8
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8,  16'h0000}, // R8 R10
    {16'h0000, 1'b1, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000}, // R5 masked
    {16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000}, // R6 disabled
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8,  16'h0000}, // R5 R6 held
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0100}, // R7
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0000}, // R8
    {16'h8001, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000}, // R6
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  16'h0000}, // R2
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0001}, // R7
    {16'h0002, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0001}, // R9 lower
    {16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0001}, // R9 equal
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0,  16'h0000}, // R8 R10
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0001}, // R7
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1,  16'h0000}, // R10
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0002}, // R7
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 4'd15, 16'h0000}, // R7 ignored ack
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h8000}, // R2 lowest
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0000}, // R8
    {16'h0008, 1'b1, 16'h0008, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000}, // R5 arrive masked
    {16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3,  16'h0000}, // R5 unmask
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0008}, // R7
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0000}, // R8
    {16'h0010, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4,  16'h0000}, // R4
    {16'h0010, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  16'h0010}, // R4 held level
    {16'h0010, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  16'h0000}, // R4 no retrigger
    {16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  16'h0000}  // R4
  };

  task automatic drive(input logic [15:0] r, input logic we, input logic [15:0] m,
                       input logic en, input logic a, input logic e);
    @(negedge clk);
    req_in = r; mask_we = we; mask_wdata = m; glob_en = en; ack = a; eoi = e;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic ep, input logic [3:0] ei,
                       input logic [15:0] es);
    n_chk++;
    if (irq_pend !== ep || irq_id !== ei || in_svc !== es) begin
      n_bad++;
      $display("FAIL %s: got pend=%0b id=%0d svc=%h, expected pend=%0b id=%0d svc=%h",
               tag, irq_pend, irq_id, in_svc, ep, ei, es);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", 1'b0, 4'd0, 16'h0000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][56:41], VEC[v][40], VEC[v][39:24], VEC[v][23], VEC[v][22], VEC[v][21]);
      check($sformatf("vector %0d", v), VEC[v][20], VEC[v][19:16], VEC[v][15:0]);
    end

    // R11: reset drops pending and mask
    drive(16'h0040, 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0);
    check("R5 all masked", 1'b0, 4'd0, 16'h0000);
    @(negedge clk); rst_n = 1'b0; req_in = '0; mask_we = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
    check("R11 pending cleared", 1'b0, 4'd0, 16'h0000);
    drive(16'h0040, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
    check("R11 mask cleared", 1'b1, 4'd6, 16'h0000);
    @(negedge clk); rst_n = 1'b0; req_in = '0;
    @(negedge clk); rst_n = 1'b1;

    // R3: class ordering with hardware failure, program fault, timer raised together
    drive(16'h0007, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
    check("R3 hw failure first", 1'b1, 4'd0, 16'h0000);
    drive(16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0);
    check("R3 R9 wait in service", 1'b0, 4'd0, 16'h0001);
    drive(16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1);
    check("R3 program next", 1'b1, 4'd1, 16'h0000);
    drive(16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0);
    drive(16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1);
    check("R3 R10 timer last", 1'b1, 4'd2, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule